// File: doc/BRIEF.md
# PC-Match Trace Trigger Controller

This block decides when a local trace buffer is filled and when filling ends. Software programs it over an APB register file. A start command opens capture and a stop command closes it. While capture is open, every valid trace word is turned into a write strobe, a word index and write data for an external trace RAM. The index walks a programmable window and returns to the window's lower bound after it passes the upper bound. Each return is counted in a saturating counter.

A trigger can also end capture. Each retired PC is compared with a programmable trigger PC. A programmable number of low bits is left out of the comparison, and the comparison can be taken in one of two senses: "inside the range" or "outside the range". The first qualifying PC loads a post-trigger countdown. When the countdown reaches zero, capture closes and, if enabled, a one-cycle pulse is sent toward the debug controller.

Top module: `trace_trig_ctrl`

## Requirements
- R1: After reset these registers read zero: control (0x04), status (0x08), address (0x10). The window-end register (0x24) reads 2047. `trig_out` is low.
- R2: Writing control (0x04) with bit 0 set and bit 1 clear starts capture. It sets status bit 0 (active) and clears status bits 1, 2 and 3. It also reloads the word index from the window start and clears the wrap count and the sticky flag. Writing bit 1 clears status bit 0, and bit 1 wins when bits 0 and 1 are written together. Control bits 2 and 3 are stored on every control write.
- R3: While status bit 0 is set, each cycle with `tw_valid` high drives `ram_we` high, `ram_addr` with the current word index, and `ram_wdata` equal to `tw_data`. While status bit 0 is clear, `ram_we` stays low.
- R4: A PC hits when the PC and the trigger PC (0x14) agree on every bit at or above position L, where L is bits 4:0 of match control (0x18). With bit 31 of 0x18 clear, a hit counts as a match. With bit 31 set, a miss counts as a match.
- R5: A valid matching PC triggers only when capture is active, control bit 2 (PC-match enable) is set, and no trigger has been seen since the last start. A trigger sets status bit 1 (trigger seen) and status bit 2 (cause was a PC match). With control bit 2 clear, a matching PC has no effect.
- R6: A trigger at clock edge E loads the 24-bit delay D from 0x1C. Status bit 0 clears at edge E+1+D, so with D = 0 capture stops on the edge after the trigger.
- R7: When capture stops through the countdown and control bit 3 (trigger output enable) is set, `trig_out` is high for exactly one cycle, starting at the same edge where status bit 0 clears, and status bit 3 is set. With control bit 3 clear, `trig_out` stays low and status bit 3 stays clear.
- R8: When a word is written at the window end (0x24), the next index is the window start (0x20), and the wrap count in address bits 30:21 increases by one. Otherwise the index increases by one. The address register returns the index in bits 10:0.
- R9: The wrap count stops at 1023. A wrap attempted at 1023 sets address bit 31, which stays set until a start command or a write to the address register.
- R10: The trigger PC, match control (bits 31 and 4:0), delay (bits 23:0), window start and window end read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 6 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data (combinational on `paddr`) |
| pc_valid | input | 1 | A PC retired this cycle |
| pc_value | input | 32 | Retired PC |
| tw_valid | input | 1 | Trace word valid |
| tw_data | input | 32 | Trace word |
| ram_we | output | 1 | Trace RAM write strobe |
| ram_addr | output | 11 | Trace RAM word index |
| ram_wdata | output | 32 | Trace RAM write data |
| trig_out | output | 1 | One-cycle trigger pulse toward the debug controller |

## Verification
The comparator is tried with a table of PC and trigger-PC pairs:
- Pairs that differ only below the ignored length separate a correctly masked compare from an exact compare.
- Pairs that differ just above that length catch an off-by-one in the mask.
- The same pairs are repeated with the sense inverted, to show that the inversion flips the outcome and does not simply force a match.
- An ignore length of 31, with the pair differing in the top bit, shows the top bit is still compared.

The countdown is observed cycle by cycle with delays of zero and three, which exposes any off-by-one in the stop edge or in the pulse width. Window walks over a three-word window, and a wrap count preloaded near its limit, separate correct wrapping from plain binary rollover and show the sticky flag.

// File: rtl/trace_trig_pkg.sv
package trace_trig_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned OFF_W  = 6;
    localparam int unsigned LEN_W  = 5;

    typedef enum logic [OFF_W-1:0] {
        OFF_CTRL   = 6'h04,
        OFF_STAT   = 6'h08,
        OFF_ADDR   = 6'h10,
        OFF_TPC    = 6'h14,
        OFF_MCTL   = 6'h18,
        OFF_DLY    = 6'h1C,
        OFF_WSTART = 6'h20,
        OFF_WEND   = 6'h24
    } reg_off_e;

    typedef struct packed {
        logic out_en;
        logic pcm_en;
    } ctrl_t;

    typedef struct packed {
        logic fired;
        logic pcm_cause;
        logic seen;
        logic active;
    } stat_t;

    typedef struct packed {
        logic             outside;
        logic [LEN_W-1:0] ign_len;
    } mctl_t;

    // Bits kept by the comparison: all positions at or above n.
    function automatic logic [DATA_W-1:0] keep_mask(input logic [LEN_W-1:0] n);
        return ~((DATA_W'(1) << n) - DATA_W'(1));
    endfunction

endpackage

// File: rtl/trace_pc_match.sv
module trace_pc_match
    import trace_trig_pkg::*;
(
    input  logic [DATA_W-1:0] pc,
    input  logic [DATA_W-1:0] tpc,
    input  mctl_t             mctl,
    output logic              hit
);
    logic [DATA_W-1:0] diff;
    logic              same;

    always_comb begin
        diff = (pc ^ tpc) & keep_mask(mctl.ign_len);
        same = (diff == '0);
        hit  = mctl.outside ? !same : same;
    end
endmodule

// File: rtl/trace_post_delay.sv
module trace_post_delay #(
    parameter int unsigned DLY_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             busy,
    output logic             expire
);
    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end
    end

    assign expire = busy && (cnt == '0);
endmodule

// File: rtl/trace_win_addr.sv
module trace_win_addr #(
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned WRAP_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              sw_wr,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [WRAP_W-1:0] sw_wrap,
    input  logic              sw_sat,
    input  logic              adv,
    input  logic [IDX_W-1:0]  win_lo,
    input  logic [IDX_W-1:0]  win_hi,
    output logic [IDX_W-1:0]  idx,
    output logic [WRAP_W-1:0] wrap_cnt,
    output logic              wrap_sat
);
    localparam logic [WRAP_W-1:0] WRAP_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx      <= '0;
            wrap_cnt <= '0;
            wrap_sat <= 1'b0;
        end else if (sw_wr) begin
            idx      <= sw_idx;
            wrap_cnt <= sw_wrap;
            wrap_sat <= sw_sat;
        end else if (restart) begin
            idx      <= win_lo;
            wrap_cnt <= '0;
            wrap_sat <= 1'b0;
        end else if (adv) begin
            if (idx == win_hi) begin
                idx <= win_lo;
                if (wrap_cnt == WRAP_MAX) wrap_sat <= 1'b1;
                else                      wrap_cnt <= wrap_cnt + 1'b1;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trace_trig_ctrl.sv
module trace_trig_ctrl
    import trace_trig_pkg::*;
#(
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned WRAP_W = 10,
    parameter int unsigned DLY_W  = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [OFF_W-1:0]  paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    input  logic              pc_valid,
    input  logic [DATA_W-1:0] pc_value,
    input  logic              tw_valid,
    input  logic [DATA_W-1:0] tw_data,
    output logic              ram_we,
    output logic [IDX_W-1:0]  ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              trig_out
);
    localparam logic [IDX_W-1:0] IDX_TOP = '1;

    ctrl_t              ctrl_q;
    stat_t              stat_q;
    mctl_t              mctl_q;
    logic [DATA_W-1:0]  tpc_q;
    logic [DLY_W-1:0]   dly_q;
    logic [IDX_W-1:0]   wlo_q;
    logic [IDX_W-1:0]   whi_q;
    logic               trig_out_q;

    logic               apb_wr;
    logic               wr_ctrl;
    logic               go_cmd;
    logic               halt_cmd;
    logic               pc_hit;
    logic               trig_fire;
    logic               dly_busy;
    logic               dly_expire;
    logic [IDX_W-1:0]   idx;
    logic [WRAP_W-1:0]  wrap_cnt;
    logic               wrap_sat;
    logic               trace_active;
    logic               trig_seen;

    assign apb_wr   = psel && penable && pwrite;
    assign wr_ctrl  = apb_wr && (paddr == OFF_CTRL);
    assign halt_cmd = wr_ctrl && pwdata[1];
    assign go_cmd   = wr_ctrl && pwdata[0] && !pwdata[1];

    assign trace_active = stat_q.active;
    assign trig_seen    = stat_q.seen;

    trace_pc_match u_match (
        .pc   (pc_value),
        .tpc  (tpc_q),
        .mctl (mctl_q),
        .hit  (pc_hit)
    );

    assign trig_fire = stat_q.active && ctrl_q.pcm_en && !stat_q.seen &&
                       pc_valid && pc_hit && !wr_ctrl;

    trace_post_delay #(.DLY_W(DLY_W)) u_delay (
        .clk      (clk),
        .rst      (rst),
        .clear    (go_cmd || halt_cmd),
        .load     (trig_fire),
        .load_val (dly_q),
        .busy     (dly_busy),
        .expire   (dly_expire)
    );

    assign ram_we    = stat_q.active && tw_valid;
    assign ram_addr  = idx;
    assign ram_wdata = tw_data;

    trace_win_addr #(.IDX_W(IDX_W), .WRAP_W(WRAP_W)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .restart  (go_cmd),
        .sw_wr    (apb_wr && (paddr == OFF_ADDR)),
        .sw_idx   (pwdata[IDX_W-1:0]),
        .sw_wrap  (pwdata[30 -: WRAP_W]),
        .sw_sat   (pwdata[31]),
        .adv      (ram_we),
        .win_lo   (wlo_q),
        .win_hi   (whi_q),
        .idx      (idx),
        .wrap_cnt (wrap_cnt),
        .wrap_sat (wrap_sat)
    );

    // Configuration registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mctl_q <= '0;
            tpc_q  <= '0;
            dly_q  <= '0;
            wlo_q  <= '0;
            whi_q  <= IDX_TOP;
        end else if (apb_wr) begin
            case (paddr)
                OFF_CTRL:   ctrl_q <= '{out_en: pwdata[3], pcm_en: pwdata[2]};
                OFF_TPC:    tpc_q  <= pwdata;
                OFF_MCTL:   mctl_q <= '{outside: pwdata[31], ign_len: pwdata[LEN_W-1:0]};
                OFF_DLY:    dly_q  <= pwdata[DLY_W-1:0];
                OFF_WSTART: wlo_q  <= pwdata[IDX_W-1:0];
                OFF_WEND:   whi_q  <= pwdata[IDX_W-1:0];
                default: ;
            endcase
        end
    end

    // Capture state and status
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q     <= '0;
            trig_out_q <= 1'b0;
        end else if (halt_cmd) begin
            stat_q.active <= 1'b0;
            trig_out_q    <= 1'b0;
        end else if (go_cmd) begin
            stat_q     <= '{fired: 1'b0, pcm_cause: 1'b0, seen: 1'b0, active: 1'b1};
            trig_out_q <= 1'b0;
        end else begin
            if (trig_fire) begin
                stat_q.seen      <= 1'b1;
                stat_q.pcm_cause <= 1'b1;
            end
            if (dly_expire) begin
                stat_q.active <= 1'b0;
                if (ctrl_q.out_en) stat_q.fired <= 1'b1;
            end
            trig_out_q <= dly_expire && ctrl_q.out_en;
        end
    end

    assign trig_out = trig_out_q;

    // Read mux
    always_comb begin
        prdata = '0;
        case (paddr)
            OFF_CTRL:   prdata[3:2] = {ctrl_q.out_en, ctrl_q.pcm_en};
            OFF_STAT:   prdata[3:0] = stat_q;
            OFF_ADDR: begin
                prdata[IDX_W-1:0]  = idx;
                prdata[30 -: WRAP_W] = wrap_cnt;
                prdata[31]         = wrap_sat;
            end
            OFF_TPC:    prdata = tpc_q;
            OFF_MCTL: begin
                prdata[31]        = mctl_q.outside;
                prdata[LEN_W-1:0] = mctl_q.ign_len;
            end
            OFF_DLY:    prdata[DLY_W-1:0] = dly_q;
            OFF_WSTART: prdata[IDX_W-1:0] = wlo_q;
            OFF_WEND:   prdata[IDX_W-1:0] = whi_q;
            default: ;
        endcase
    end

    logic unused_busy;
    assign unused_busy = dly_busy;
endmodule

// File: rtl/trace_trig_chk.sv
module trace_trig_chk #(
    parameter int unsigned IDX_W  = 11,
    parameter int unsigned WRAP_W = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              apb_wr,
    input logic              trig_out,
    input logic              active,
    input logic              seen,
    input logic              ram_we,
    input logic [IDX_W-1:0]  ram_addr,
    input logic [IDX_W-1:0]  win_lo,
    input logic [IDX_W-1:0]  win_hi,
    input logic [WRAP_W-1:0] wrap_cnt,
    input logic              wrap_sat
);
    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trig_out |=> !trig_out); // R7

    AST_PULSE_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> !active); // R6

    AST_PULSE_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        trig_out |-> seen); // R5

    AST_WRAP_TO_START: assert property (@(posedge clk) disable iff (rst)
        (ram_we && ram_addr == win_hi && !apb_wr) |=> ram_addr == $past(win_lo)); // R8

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (wrap_cnt == '1 && !apb_wr) |=> wrap_cnt == '1); // R9

    AST_SAT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (wrap_sat && !apb_wr) |=> wrap_sat); // R9
endmodule

bind trace_trig_ctrl trace_trig_chk #(.IDX_W(IDX_W), .WRAP_W(WRAP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .apb_wr   (apb_wr),
    .trig_out (trig_out),
    .active   (trace_active),
    .seen     (trig_seen),
    .ram_we   (ram_we),
    .ram_addr (ram_addr),
    .win_lo   (wlo_q),
    .win_hi   (whi_q),
    .wrap_cnt (wrap_cnt),
    .wrap_sat (wrap_sat)
);

// File: tb/tb_trace_trig_ctrl.sv
`timescale 1ns/1ps
module tb_trace_trig_ctrl;

    logic        clk = 1'b0;
    logic        rst;
    logic        psel, penable, pwrite;
    logic [5:0]  paddr;
    logic [31:0] pwdata, prdata;
    logic        pc_valid;
    logic [31:0] pc_value;
    logic        tw_valid;
    logic [31:0] tw_data;
    logic        ram_we;
    logic [10:0] ram_addr;
    logic [31:0] ram_wdata;
    logic        trig_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    trace_trig_ctrl dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pc_valid(pc_valid), .pc_value(pc_value),
        .tw_valid(tw_valid), .tw_data(tw_data),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .trig_out(trig_out)
    );

    localparam logic [5:0] A_CTRL = 6'h04, A_STAT = 6'h08, A_ADDR = 6'h10,
                           A_TPC = 6'h14, A_MCTL = 6'h18, A_DLY = 6'h1C,
                           A_WSTART = 6'h20, A_WEND = 6'h24;

    typedef struct packed {
        logic [4:0]  len;
        logic        inv;
        logic [31:0] tpc;
        logic [31:0] pc;
        logic        match;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{5'd0,  1'b0, 32'h0000_1000, 32'h0000_1000, 1'b1},
        '{5'd0,  1'b0, 32'h0000_1000, 32'h0000_1004, 1'b0},
        '{5'd4,  1'b0, 32'h0000_1000, 32'h0000_100C, 1'b1},
        '{5'd4,  1'b0, 32'h0000_1000, 32'h0000_1010, 1'b0},
        '{5'd4,  1'b1, 32'h0000_1000, 32'h0000_1010, 1'b1},
        '{5'd4,  1'b1, 32'h0000_1000, 32'h0000_100C, 1'b0},
        '{5'd31, 1'b0, 32'h0000_0000, 32'h7FFF_FFFF, 1'b1},
        '{5'd31, 1'b0, 32'h0000_0000, 32'h8000_0000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(posedge clk);
        #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        paddr = a;
        #1;
        d = prdata;
    endtask

    task automatic pc_pulse(input logic [31:0] pc);
        @(negedge clk);
        pc_valid = 1'b1; pc_value = pc;
        @(negedge clk);
        pc_valid = 1'b0;
    endtask

    task automatic push_word(input logic [31:0] d, input logic [10:0] exp_addr, input string req);
        @(negedge clk);
        tw_valid = 1'b1; tw_data = d;
        #1;
        chk({req, " we"}, {31'd0, ram_we}, 32'd1);
        chk({req, " addr"}, {21'd0, ram_addr}, {21'd0, exp_addr});
        chk({req, " data"}, ram_wdata, d);
        @(posedge clk);
        #1;
        tw_valid = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
        pc_valid = 0; pc_value = '0; tw_valid = 0; tw_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(A_STAT, v);  chk("R1 status", v, 32'd0);
        rd(A_CTRL, v);  chk("R1 ctrl", v, 32'd0);
        rd(A_ADDR, v);  chk("R1 addr", v, 32'd0);
        rd(A_WEND, v);  chk("R1 window end", v, 32'd2047);
        chk("R1 trig_out", {31'd0, trig_out}, 32'd0);
        // R3 idle: no write strobe
        tw_valid = 1'b1; #1;
        chk("R3 idle no we", {31'd0, ram_we}, 32'd0);
        tw_valid = 1'b0;

        // R4 / R5: compare table walked by one loop, delay 0
        wr(A_DLY, 32'd0);
        for (int i = 0; i < NVEC; i++) begin
            wr(A_MCTL, {VECS[i].inv, 26'd0, VECS[i].len});
            wr(A_TPC, VECS[i].tpc);
            wr(A_CTRL, 32'h5);
            pc_pulse(VECS[i].pc);
            @(negedge clk);
            rd(A_STAT, v);
            chk($sformatf("R4 vec%0d status", i), v, VECS[i].match ? 32'h6 : 32'h1);
            wr(A_CTRL, 32'h2);
        end

        // R6 / R7: delay 3 with output enabled
        wr(A_MCTL, 32'd0);
        wr(A_TPC, 32'h2000);
        wr(A_DLY, 32'd3);
        wr(A_CTRL, 32'hD);
        pc_pulse(32'h2000);
        paddr = A_STAT;
        for (int k = 1; k <= 5; k++) begin
            @(negedge clk);
            chk($sformatf("R7 trig_out k=%0d", k), {31'd0, trig_out}, (k == 4) ? 32'd1 : 32'd0);
            chk($sformatf("R6 active k=%0d", k), {31'd0, prdata[0]}, (k < 4) ? 32'd1 : 32'd0);
        end
        rd(A_STAT, v); chk("R7 fired status", v, 32'hE);

        // R6 / R7: delay 0, output disabled
        wr(A_DLY, 32'd0);
        wr(A_CTRL, 32'h5);
        pc_pulse(32'h2000);
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk($sformatf("R7 no pulse k=%0d", k), {31'd0, trig_out}, 32'd0);
        end
        rd(A_STAT, v); chk("R6 delay0 stopped", v, 32'h6);

        // R2 start clears trigger status
        wr(A_CTRL, 32'h1);
        rd(A_STAT, v); chk("R2 start clears", v, 32'h1);
        // R5 PC-match disabled: no effect
        pc_pulse(32'h2000);
        @(negedge clk);
        rd(A_STAT, v); chk("R5 pcm disabled", v, 32'h1);
        wr(A_CTRL, 32'h2);
        rd(A_STAT, v); chk("R2 stop", v, 32'h0);
        wr(A_CTRL, 32'h3);
        rd(A_STAT, v); chk("R2 stop wins", v, 32'h0);

        // R8 window wrap
        wr(A_WSTART, 32'd5);
        wr(A_WEND, 32'd7);
        wr(A_CTRL, 32'h1);
        push_word(32'hA0, 11'd5, "R8 w0");
        push_word(32'hA1, 11'd6, "R8 w1");
        push_word(32'hA2, 11'd7, "R8 w2");
        push_word(32'hA3, 11'd5, "R8 w3");
        push_word(32'hA4, 11'd6, "R8 w4");
        push_word(32'hA5, 11'd7, "R8 w5");
        push_word(32'hA6, 11'd5, "R8 w6");
        rd(A_ADDR, v); chk("R8 addr reg", v, (32'd2 << 21) | 32'd6);

        // R9 saturation
        wr(A_ADDR, (32'd1022 << 21) | 32'd7);
        push_word(32'hB0, 11'd7, "R9 w0");
        rd(A_ADDR, v); chk("R9 at max", v, (32'd1023 << 21) | 32'd5);
        push_word(32'hB1, 11'd5, "R9 w1");
        push_word(32'hB2, 11'd6, "R9 w2");
        push_word(32'hB3, 11'd7, "R9 w3");
        rd(A_ADDR, v); chk("R9 sticky", v, 32'h8000_0000 | (32'd1023 << 21) | 32'd5);
        push_word(32'hB4, 11'd5, "R9 w4");
        rd(A_ADDR, v); chk("R9 still sticky", v[31:21], {1'b1, 10'd1023});
        wr(A_CTRL, 32'h1);
        rd(A_ADDR, v); chk("R2 restart addr", v, 32'd5);

        // R3 after stop
        wr(A_CTRL, 32'h2);
        tw_valid = 1'b1; #1;
        chk("R3 stopped no we", {31'd0, ram_we}, 32'd0);
        tw_valid = 1'b0;

        // R10 readback
        wr(A_TPC, 32'hDEAD_BEEF);
        wr(A_MCTL, 32'hFFFF_FFFF);
        wr(A_DLY, 32'hFFAB_CDEF);
        wr(A_WSTART, 32'd1234);
        wr(A_WEND, 32'd1500);
        rd(A_TPC, v);    chk("R10 tpc", v, 32'hDEAD_BEEF);
        rd(A_MCTL, v);   chk("R10 mctl", v, 32'h8000_001F);
        rd(A_DLY, v);    chk("R10 delay", v, 32'h00AB_CDEF);
        rd(A_WSTART, v); chk("R10 wstart", v, 32'd1234);
        rd(A_WEND, v);   chk("R10 wend", v, 32'd1500);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule